// File: doc/BRIEF.md
# Write Burst Command Splitter

This block turns one large write request into a series of legal write-address commands for a memory-mapped burst bus. A request carries a start byte address, a total byte count and a mode bit. The block derives the number of beats from the data-bus width, then hands out commands one at a time on a valid/ready port. Each command carries an address, a length field (beats minus one) and a beat-size code.

Every command is capped at a parameterized maximum beat count, 16 by default. In incrementing mode, a command is also cut short so that it never runs past a 4 KB address page. In fixed mode, all commands repeat the start address and only the beat cap applies.

A request is taken only while the block is idle. A one-cycle done pulse follows the handshake of the last command. A request with a zero byte count yields the pulse without any command. Moving the write data and collecting responses are left to other blocks.

Top module: `wsplit_top`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid is 0 and done is 0.
- R2: The beats of all commands of one request add up to the byte count divided by DATA_W/8 (8 bytes per beat by default). Without page cuts, the number of commands is that beat count divided by MAX_BEATS, rounded up.
- R3: cmd_len equals the beat count of the command minus one, and no command exceeds MAX_BEATS beats (16 by default).
- R4: In incrementing mode (req_fixed = 0), each command's beat count is the minimum of three values: the remaining beats, MAX_BEATS, and the beats left before the next 4096-byte boundary. No command crosses such a boundary.
- R5: In incrementing mode, the first command uses the start address. Each later command's address is the previous address plus the previous beat count times the bytes per beat.
- R6: In fixed mode (req_fixed = 1), every command carries the start address. Its beat count is the minimum of the remaining beats and MAX_BEATS, with no page cut.
- R7: Once cmd_valid is high, it stays high with cmd_addr and cmd_len unchanged until a cycle in which cmd_ready is high.
- R8: cmd_size equals log2(DATA_W/8), which is 3 by default.
- R9: done is high for exactly the one cycle after the handshake of the final command. cmd_valid is low in that cycle.
- R10: req_ready is high only while no request is in progress. A req_valid held while busy is ignored, and it adds no commands.
- R11: A request with a byte count of 0 gives done in the following cycle and issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken |
| req_addr | input | ADDR_W | Start byte address, aligned to the beat size |
| req_bytes | input | BYTES_W | Total byte count, a multiple of the beat size |
| req_fixed | input | 1 | 1 = fixed address, 0 = incrementing |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command taken by the bus |
| cmd_addr | output | ADDR_W | Command start address |
| cmd_len | output | 8 | Beats minus one |
| cmd_size | output | 3 | log2 of bytes per beat |
| done | output | 1 | One-cycle pulse when the request is complete |

## Verification
The assertions assume two things about each request: its start address is aligned to the beat size, and its byte count is a whole number of beats. They also assume that a request's beat count fits the remaining-beat counter. The stimulus table uses only aligned addresses and byte counts that are multiples of 8, so every vector stays within these limits. The vectors include starts placed a few beats short of a 4 KB page. cmd_ready is stalled on a fixed pattern, so the hold property is exercised on real waits, and every step property is exercised on real handshakes.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;

    localparam int PAGE_BYTES = 4096;
    localparam int PAGE_LOG   = 12;
    localparam int AXI_LEN_W  = 8;
    localparam int AXI_SIZE_W = 3;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } wsplit_state_e;

    typedef struct packed {
        logic load;
        logic step;
    } wsplit_ctl_t;

    function automatic int unsigned beat_log(input int unsigned data_w);
        return $clog2(data_w / 8);
    endfunction

endpackage

// File: rtl/wsplit_len_calc.sv
module wsplit_len_calc
    import wsplit_pkg::*;
#(
    parameter int CNT_W     = 20,
    parameter int SIZE_LOG  = 3,
    parameter int MAX_BEATS = 16
) (
    input  logic [PAGE_LOG-1:0] page_off,
    input  logic [CNT_W-1:0]    remain,
    input  logic                fixed_mode,
    output logic [CNT_W-1:0]    beats
);
    localparam int ROOM_W = PAGE_LOG + 1;

    logic [ROOM_W-1:0] room_bytes;
    logic [CNT_W-1:0]  room_beats;
    logic [CNT_W-1:0]  capped;

    always_comb begin
        room_bytes = ROOM_W'(PAGE_BYTES) - {1'b0, page_off};
        room_beats = CNT_W'(room_bytes >> SIZE_LOG);
        capped     = (remain < CNT_W'(MAX_BEATS)) ? remain : CNT_W'(MAX_BEATS);
    end

    generate
        if (MAX_BEATS * (1 << SIZE_LOG) > PAGE_BYTES) begin : g_page_always
            always_comb beats = (!fixed_mode && room_beats < capped) ? room_beats : capped;
        end else begin : g_page_check
            always_comb begin
                beats = capped;
                if (!fixed_mode && room_beats < capped)
                    beats = room_beats;
            end
        end
    endgenerate

    always_comb begin
        if (remain != '0) begin
            a_r4_len_nonzero : assert (beats != '0 && beats <= remain);
        end
    end

endmodule

// File: rtl/wsplit_cursor.sv
module wsplit_cursor
    import wsplit_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 20,
    parameter int SIZE_LOG = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  wsplit_ctl_t       ctl,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [CNT_W-1:0]  ld_beats,
    input  logic              ld_fixed,
    input  logic [CNT_W-1:0]  step_beats,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_remain,
    output logic              cur_fixed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr   <= '0;
            cur_remain <= '0;
            cur_fixed  <= 1'b0;
        end else if (ctl.load) begin
            cur_addr   <= ld_addr;
            cur_remain <= ld_beats;
            cur_fixed  <= ld_fixed;
        end else if (ctl.step) begin
            cur_remain <= cur_remain - step_beats;
            if (!cur_fixed)
                cur_addr <= cur_addr + (ADDR_W'(step_beats) << SIZE_LOG);
        end
    end

    a_r2_no_underflow : assert property (@(posedge clk) disable iff (rst)
        ctl.step |-> (step_beats <= cur_remain && step_beats != '0));

endmodule

// File: rtl/wsplit_top.sv
module wsplit_top
    import wsplit_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 64,
    parameter int MAX_BEATS = 16,
    parameter int BYTES_W   = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [BYTES_W-1:0]    req_bytes,
    input  logic                  req_fixed,
    output logic                  cmd_valid,
    input  logic                  cmd_ready,
    output logic [ADDR_W-1:0]     cmd_addr,
    output logic [AXI_LEN_W-1:0]  cmd_len,
    output logic [AXI_SIZE_W-1:0] cmd_size,
    output logic                  done
);
    localparam int SIZE_LOG = beat_log(DATA_W);
    localparam int CNT_W    = BYTES_W;

    wsplit_state_e    state_q;
    wsplit_ctl_t      ctl;
    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] beats;
    logic             fixed_q;
    logic             last_burst;
    logic             done_q;

    assign req_ready  = (state_q == ST_IDLE);
    assign cmd_valid  = (state_q == ST_ISSUE);
    assign last_burst = (remain_q == beats);
    assign ctl.load   = req_ready && req_valid && (req_bytes != '0);
    assign ctl.step   = cmd_valid && cmd_ready;

    wsplit_cursor #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .SIZE_LOG (SIZE_LOG)
    ) cursor_i (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .ld_addr    (req_addr),
        .ld_beats   (req_bytes >> SIZE_LOG),
        .ld_fixed   (req_fixed),
        .step_beats (beats),
        .cur_addr   (cmd_addr),
        .cur_remain (remain_q),
        .cur_fixed  (fixed_q)
    );

    wsplit_len_calc #(
        .CNT_W     (CNT_W),
        .SIZE_LOG  (SIZE_LOG),
        .MAX_BEATS (MAX_BEATS)
    ) len_i (
        .page_off   (cmd_addr[PAGE_LOG-1:0]),
        .remain     (remain_q),
        .fixed_mode (fixed_q),
        .beats      (beats)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_bytes == '0) done_q <= 1'b1;
                        else                 state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (cmd_ready && last_burst) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done     = done_q;
    assign cmd_len  = AXI_LEN_W'(beats - CNT_W'(1));
    assign cmd_size = AXI_SIZE_W'(SIZE_LOG);

    a_r7_hold_payload : assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len));

    a_r3_len_cap : assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_len < AXI_LEN_W'(MAX_BEATS)));

    a_r4_no_page_cross : assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !fixed_q |->
            ({1'b0, cmd_addr[PAGE_LOG-1:0]} + ((PAGE_LOG+1)'(cmd_len) + 1'b1) * (PAGE_LOG+1)'(1 << SIZE_LOG))
                <= (PAGE_LOG+1)'(PAGE_BYTES));

    a_r5_incr_step : assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && !fixed_q && !last_burst |=>
            cmd_addr == $past(cmd_addr) + ((ADDR_W'($past(cmd_len)) + 1'b1) << SIZE_LOG));

    a_r6_fixed_addr : assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && fixed_q && !last_burst |=> $stable(cmd_addr));

    a_r9_done_quiet : assert property (@(posedge clk) disable iff (rst)
        done |-> !cmd_valid && req_ready);

    a_r9_done_cause : assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && last_burst |=> done);

    a_r11_zero_done : assert property (@(posedge clk) disable iff (rst)
        req_ready && req_valid && req_bytes == '0 |=> done && !cmd_valid);

endmodule

// File: tb/wsplit_top_tb_top.sv
`timescale 1ns/1ps
module wsplit_top_tb_top;

    localparam int NV = 9;
    localparam logic [31:0] V_ADDR  [NV] = '{32'h0000_0000, 32'h0000_0000, 32'h0000_0FC0,
                                             32'h0000_1FF8, 32'h0000_0FC0, 32'h0000_2000,
                                             32'h0000_3F80, 32'h0000_0008, 32'h0000_0FF8};
    localparam logic [19:0] V_BYTES [NV] = '{20'd128, 20'd1024, 20'd256, 20'd16, 20'd256,
                                             20'd200, 20'd4096, 20'd8, 20'd24};
    localparam logic        V_FIXED [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam int          V_NB    [NV] = '{1, 8, 3, 2, 2, 2, 32, 1, 1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [19:0] req_bytes = '0;
    logic        req_fixed = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_addr;
    logic [7:0]  cmd_len;
    logic [2:0]  cmd_size;
    logic        done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wsplit_top dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_bytes(req_bytes), .req_fixed(req_fixed),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_size(cmd_size), .done(done)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_len(input logic [31:0] a, input int rem, input logic fx);
        int m;
        int room;
        m = (rem < 16) ? rem : 16;
        room = (4096 - int'(a[11:0])) / 8;
        if (!fx && room < m) m = room;
        return m;
    endfunction

    task automatic run_req(input logic [31:0] a, input logic [19:0] b, input logic fx,
                           input int exp_nb, input bit spam);
        logic [31:0] m_addr;
        int          m_rem;
        int          nb;
        int          sum;
        int          cyc;
        int          el;
        logic [31:0] s_addr;
        logic [7:0]  s_len;
        m_addr = a; m_rem = int'(b) / 8; nb = 0; sum = 0; cyc = 0;
        req_addr = a; req_bytes = b; req_fixed = fx; req_valid = 1'b1;
        @(negedge clk);
        if (spam) begin
            req_addr = 32'h0000_5000; req_bytes = 20'd64; req_fixed = 1'b0;
        end else begin
            req_valid = 1'b0;
        end
        while (m_rem != 0 && cyc < 2000) begin
            cyc++;
            if (!cmd_valid) begin
                chk("R7 valid present", cmd_valid, 1);
                break;
            end
            chk("R10 busy not ready", req_ready, 0);
            if (cyc % 3 == 2) begin
                cmd_ready = 1'b0;
                s_addr = cmd_addr; s_len = cmd_len;
                @(negedge clk);
                chk("R7 hold valid", cmd_valid, 1);
                chk("R7 hold addr", cmd_addr, s_addr);
                chk("R7 hold len", cmd_len, s_len);
            end else begin
                el = model_len(m_addr, m_rem, fx);
                chk(fx ? "R6 addr" : "R5 addr", cmd_addr, m_addr);
                chk(fx ? "R6 len" : "R4 len", cmd_len, el - 1);
                chk("R8 size", cmd_size, 3);
                cmd_ready = 1'b1;
                if (m_rem == el) req_valid = 1'b0;
                nb++; sum += el; m_rem -= el;
                if (!fx) m_addr = m_addr + 32'(el * 8);
                @(negedge clk);
                cmd_ready = 1'b0;
            end
        end
        chk("R9 done pulse", done, 1);
        chk("R9 valid low at done", cmd_valid, 0);
        chk("R2 burst count", nb, exp_nb);
        chk("R2 beat sum", sum, int'(b) / 8);
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
    endtask

    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 req_ready", req_ready, 1);
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R1 done", done, 0);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_req(V_ADDR[i], V_BYTES[i], V_FIXED[i], V_NB[i], 1'b0);
            @(negedge clk);
        end

        // R11: zero byte count
        req_addr = 32'h100; req_bytes = '0; req_fixed = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 done", done, 1);
        chk("R11 no command", cmd_valid, 0);
        @(negedge clk);
        chk("R11 done clears", done, 0);
        chk("R11 still idle", req_ready, 1);
        chk("R11 no command later", cmd_valid, 0);

        // R10: request held high while busy is ignored
        run_req(32'h0000_0400, 20'd1024, 1'b0, 8, 1'b1);
        for (int k = 0; k < 3; k++) begin
            chk("R10 no extra command", cmd_valid, 0);
            @(negedge clk);
        end

        // R3: long fixed transfer, many capped bursts
        run_req(32'h0000_0FF8, 20'd1000, 1'b1, 8, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule